// File: doc/BRIEF.md
# Crypto Accelerator Bus Register Wrapper

This block is the software-facing shell of a modular-exponentiation engine. A 32-bit chip-select/write-enable bus reaches it. The top address bit splits the space in two. One half holds a small register file with identification, control, status, mode, length and capability registers. The other half holds eight word-addressed operand banks. The engine itself sits outside this block. It receives start pulses, the mode and both operand lengths, and it owns a read port into the operand banks and a write port into the result-type banks.

To start an operation, software writes 0 and then 1 to a control bit and polls status until the matching flag rises. The wrapper turns only the rising transition of each control bit into a one-clock start strobe. The engine computes two modulus-dependent quantities: a speed-up coefficient and a Montgomery factor. Each of them has an output bank, which the engine fills, and an input bank, which software fills. Software can therefore save the precomputed values once and load them back later for a modulus it has already processed.

Top module: `crypto_bus_wrap`

## Requirements
- R1: A read takes data from the sample edge of chip select with write enable low, and that data is on `bus_rdata` one clock later. Register 0x00 reads 0x6D6F6465, 0x01 reads 0x78706137 and 0x02 reads 0x302E3235.
- R2: Register-space reads of an address that maps to no register return zero. Writes to the read-only registers 0x00, 0x01, 0x02, 0x09, 0x13 and 0x14 leave their read values unchanged.
- R3: While `rst_n` is low at a clock edge, the control, mode and both length registers clear to zero. This reset is synchronous and active low.
- R4: Register 0x08 bit 0 is the precompute request. A bus write that takes this bit from 0 to 1 makes `init_trig` high for exactly the one clock after the write edge.
- R5: Register 0x08 bit 1 is the exponentiate request, and `next_trig` follows the same rule as R4. A write that leaves a control bit at 1 produces no pulse. Register 0x08 reads back the last value written to bits 1:0.
- R6: Register 0x09 reads the engine's `eng_ready` flag in bit 0 and its `eng_valid` flag in bit 1. All other bits read zero.
- R7: Register 0x10 holds mode bits 1:0, and bit 1 drives `crt_en`. Register 0x11 holds the modulus length and drives `mod_len`. Register 0x12 holds the exponent length and drives `exp_len`. All three read back what was written.
- R8: When `bus_addr` MSB is 1, the next three bits select a bank and the low OP_AW bits select a word, where word 0 is the least significant word. The bank codes are 000 modulus, 001 message, 010 exponent, 011 result, 100 coefficient out, 101 coefficient in, 110 factor out and 111 factor in. Bus writes to banks 000, 001, 010, 101 and 111 read back.
- R9: Bus writes to banks 011, 100 and 110 are ignored. Words that the engine writes into those banks are readable from the bus.
- R10: The engine read port returns the selected bank word one clock after `eng_rd_bank` and `eng_rd_addr` are sampled.
- R11: Register 0x13 reads 32·2^OP_AW, the largest operand width in bits. Register 0x14 reads ARRAY_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Chip select, one access per cycle |
| bus_we | input | 1 | Write enable (1 write, 0 read) |
| bus_addr | input | OP_AW+4 | Word address; MSB selects bank space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the access |
| init_trig | output | 1 | One-clock precompute start strobe |
| next_trig | output | 1 | One-clock exponentiate start strobe |
| crt_en | output | 1 | Mode bit 1 to the engine |
| mod_len | output | 32 | Modulus length in bits |
| exp_len | output | 32 | Exponent length in bits |
| eng_ready | input | 1 | Engine precompute-done flag |
| eng_valid | input | 1 | Engine exponentiate-done flag |
| eng_rd_bank | input | 3 | Engine read bank code |
| eng_rd_addr | input | OP_AW | Engine read word index |
| eng_rd_data | output | 32 | Engine read data, one clock later |
| eng_wr_en | input | 1 | Engine write strobe |
| eng_wr_bank | input | 3 | Engine write bank code (011, 100, 110 accepted) |
| eng_wr_addr | input | OP_AW | Engine write word index |
| eng_wr_data | input | 32 | Engine write data |

## Verification
The bench builds the block with OP_AW = 4 and ARRAY_BITS = 64. This gives an 8-bit bus address, 16-word banks and a capability value of 512. At this size every register offset up to 0x14 and every one of the eight bank codes can be reached with only a few words per bank. A stub engine answers each strobe after a fixed delay. It writes known words into the coefficient, factor and result banks, so the bench can drive full precompute and exponentiate handshakes, including the save-and-restore of coefficients between paired banks.

// File: rtl/cbw_pkg.sv
// Package: shared constants for the crypto bus wrapper.
// Assumes register offsets fit in 5 bits (OP_AW >= 2 at the top).
package cbw_pkg;
    localparam logic [31:0] ID_WORD0   = 32'h6D6F6465;
    localparam logic [31:0] ID_WORD1   = 32'h78706137;
    localparam logic [31:0] VER_WORD   = 32'h302E3235;

    localparam logic [7:0]  OFS_ID0    = 8'h00;
    localparam logic [7:0]  OFS_ID1    = 8'h01;
    localparam logic [7:0]  OFS_VER    = 8'h02;
    localparam logic [7:0]  OFS_CTRL   = 8'h08;
    localparam logic [7:0]  OFS_STAT   = 8'h09;
    localparam logic [7:0]  OFS_MODE   = 8'h10;
    localparam logic [7:0]  OFS_MLEN   = 8'h11;
    localparam logic [7:0]  OFS_ELEN   = 8'h12;
    localparam logic [7:0]  OFS_BUFW   = 8'h13;
    localparam logic [7:0]  OFS_ARRW   = 8'h14;

    localparam int NUM_BANKS = 8;

    // Banks the engine writes; the bus may only read them.
    function automatic logic engine_owned(input int idx);
        return (idx == 3) || (idx == 4) || (idx == 6);
    endfunction
endpackage

// File: rtl/cbw_regs.sv
// Register file: identification, control, status, mode and lengths.
// Turns control-bit rising writes into one-clock start strobes.
// Assumes one access per cycle; read data registered (one-clock latency).
module cbw_regs
    import cbw_pkg::*;
#(
    parameter int RA_W       = 7,
    parameter int BUF_BITS   = 512,
    parameter int ARRAY_BITS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    input  logic            eng_ready,
    input  logic            eng_valid,
    output logic            init_trig,
    output logic            next_trig,
    output logic            crt_en,
    output logic [31:0]     mod_len,
    output logic [31:0]     exp_len
);
    localparam logic [RA_W-1:0] A_ID0  = RA_W'(OFS_ID0);
    localparam logic [RA_W-1:0] A_ID1  = RA_W'(OFS_ID1);
    localparam logic [RA_W-1:0] A_VER  = RA_W'(OFS_VER);
    localparam logic [RA_W-1:0] A_CTRL = RA_W'(OFS_CTRL);
    localparam logic [RA_W-1:0] A_STAT = RA_W'(OFS_STAT);
    localparam logic [RA_W-1:0] A_MODE = RA_W'(OFS_MODE);
    localparam logic [RA_W-1:0] A_MLEN = RA_W'(OFS_MLEN);
    localparam logic [RA_W-1:0] A_ELEN = RA_W'(OFS_ELEN);
    localparam logic [RA_W-1:0] A_BUFW = RA_W'(OFS_BUFW);
    localparam logic [RA_W-1:0] A_ARRW = RA_W'(OFS_ARRW);

    logic [1:0]  ctrl_q;
    logic [1:0]  mode_q;
    logic [31:0] mlen_q;
    logic [31:0] elen_q;
    logic [31:0] rd_mux;
    logic        wr_ctrl;

    assign wr_ctrl = wr_en && (reg_addr == A_CTRL);

    // Writable registers: control, mode and the two lengths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            mlen_q <= '0;
            elen_q <= '0;
        end else if (wr_en) begin
            if (reg_addr == A_CTRL) ctrl_q <= wdata[1:0];
            if (reg_addr == A_MODE) mode_q <= wdata[1:0];
            if (reg_addr == A_MLEN) mlen_q <= wdata;
            if (reg_addr == A_ELEN) elen_q <= wdata;
        end
    end

    // Start strobes: only a 0-to-1 change of a control bit fires one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_trig <= 1'b0;
            next_trig <= 1'b0;
        end else begin
            init_trig <= wr_ctrl && wdata[0] && !ctrl_q[0];
            next_trig <= wr_ctrl && wdata[1] && !ctrl_q[1];
        end
    end

    // Read decode; unmapped offsets give zero.
    always_comb begin
        case (reg_addr)
            A_ID0:   rd_mux = ID_WORD0;
            A_ID1:   rd_mux = ID_WORD1;
            A_VER:   rd_mux = VER_WORD;
            A_CTRL:  rd_mux = {30'd0, ctrl_q};
            A_STAT:  rd_mux = {30'd0, eng_valid, eng_ready};
            A_MODE:  rd_mux = {30'd0, mode_q};
            A_MLEN:  rd_mux = mlen_q;
            A_ELEN:  rd_mux = elen_q;
            A_BUFW:  rd_mux = 32'(BUF_BITS);
            A_ARRW:  rd_mux = 32'(ARRAY_BITS);
            default: rd_mux = 32'd0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign crt_en  = mode_q[1];
    assign mod_len = mlen_q;
    assign exp_len = elen_q;
endmodule

// File: rtl/cbw_bank.sv
// One operand bank: a single write port and two registered read ports
// (bus side and engine side). The memory is not reset.
module cbw_bank #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_a_addr,
    output logic [31:0]   rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [31:0]   rd_b_data
);
    localparam int DEPTH = 1 << AW;

    logic [31:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Both read ports, one-clock latency.
    always_ff @(posedge clk) begin
        rd_a_data <= mem[rd_a_addr];
        rd_b_data <= mem[rd_b_addr];
    end
endmodule

// File: rtl/crypto_bus_wrap.sv
// Top: splits the bus between the register file and eight operand banks.
// The address MSB selects bank space. Input banks take bus writes, and
// output banks take engine writes. The read mux follows the registered
// select.
module crypto_bus_wrap
    import cbw_pkg::*;
#(
    parameter int OP_AW      = 4,
    parameter int ARRAY_BITS = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_cs,
    input  logic               bus_we,
    input  logic [OP_AW+3:0]   bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               init_trig,
    output logic               next_trig,
    output logic               crt_en,
    output logic [31:0]        mod_len,
    output logic [31:0]        exp_len,
    input  logic               eng_ready,
    input  logic               eng_valid,
    input  logic [2:0]         eng_rd_bank,
    input  logic [OP_AW-1:0]   eng_rd_addr,
    output logic [31:0]        eng_rd_data,
    input  logic               eng_wr_en,
    input  logic [2:0]         eng_wr_bank,
    input  logic [OP_AW-1:0]   eng_wr_addr,
    input  logic [31:0]        eng_wr_data
);
    localparam int ADDR_W   = OP_AW + 4;
    localparam int RA_W     = ADDR_W - 1;
    localparam int BUF_BITS = 32 << OP_AW;

    logic             in_bank;
    logic [2:0]       bank_sel;
    logic [OP_AW-1:0] word_sel;
    logic             bank_q;
    logic [2:0]       bank_sel_q;
    logic [2:0]       eng_sel_q;
    logic [31:0]      reg_rdata;
    logic [31:0]      bus_rd [NUM_BANKS];
    logic [31:0]      eng_rd [NUM_BANKS];

    assign in_bank  = bus_addr[ADDR_W-1];
    assign bank_sel = bus_addr[ADDR_W-2 -: 3];
    assign word_sel = bus_addr[OP_AW-1:0];

    cbw_regs #(
        .RA_W(RA_W), .BUF_BITS(BUF_BITS), .ARRAY_BITS(ARRAY_BITS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_cs && bus_we && !in_bank),
        .rd_en(bus_cs && !bus_we && !in_bank),
        .reg_addr(bus_addr[RA_W-1:0]), .wdata(bus_wdata), .rdata(reg_rdata),
        .eng_ready(eng_ready), .eng_valid(eng_valid),
        .init_trig(init_trig), .next_trig(next_trig),
        .crt_en(crt_en), .mod_len(mod_len), .exp_len(exp_len)
    );

    // Bank array: the write source is picked per bank by ownership.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             w_en;
        logic [OP_AW-1:0] w_addr;
        logic [31:0]      w_data;
        if (engine_owned(b)) begin : g_eng
            assign w_en   = eng_wr_en && (eng_wr_bank == 3'(b));
            assign w_addr = eng_wr_addr;
            assign w_data = eng_wr_data;
        end else begin : g_bus
            assign w_en   = bus_cs && bus_we && in_bank && (bank_sel == 3'(b));
            assign w_addr = word_sel;
            assign w_data = bus_wdata;
        end
        cbw_bank #(.AW(OP_AW)) u_bank (
            .clk(clk), .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
            .rd_a_addr(word_sel), .rd_a_data(bus_rd[b]),
            .rd_b_addr(eng_rd_addr), .rd_b_data(eng_rd[b])
        );
    end

    // Remember which space and bank the pending reads target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q     <= 1'b0;
            bank_sel_q <= '0;
            eng_sel_q  <= '0;
        end else begin
            if (bus_cs && !bus_we) begin
                bank_q     <= in_bank;
                bank_sel_q <= bank_sel;
            end
            eng_sel_q <= eng_rd_bank;
        end
    end

    // Read data muxes for bus and engine.
    always_comb begin
        bus_rdata   = bank_q ? bus_rd[bank_sel_q] : reg_rdata;
        eng_rd_data = eng_rd[eng_sel_q];
    end
endmodule

// File: rtl/cbw_checker.sv
// Checker bound to crypto_bus_wrap: strobe shape and cause, reset
// state and mode-hold rules, all seen at the top ports.
module cbw_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_cs,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              init_trig,
    input logic              next_trig,
    input logic              crt_en,
    input logic [31:0]       mod_len,
    input logic [31:0]       exp_len
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(8'h10);

    logic wr_ctrl;
    logic wr_mode;
    assign wr_ctrl = bus_cs && bus_we && (bus_addr == CTRL_A);
    assign wr_mode = bus_cs && bus_we && (bus_addr == MODE_A);

    AST_INIT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        init_trig |=> !init_trig); // R4
    AST_INIT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        init_trig |-> $past(wr_ctrl && bus_wdata[0])); // R4
    AST_NEXT_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        next_trig |=> !next_trig); // R5
    AST_NEXT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        next_trig |-> $past(wr_ctrl && bus_wdata[1])); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!crt_en && mod_len == 32'd0 && exp_len == 32'd0)); // R3
    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_mode) |-> $stable(crt_en)); // R7
endmodule

bind crypto_bus_wrap cbw_checker #(.ADDR_W(OP_AW + 4)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .init_trig(init_trig), .next_trig(next_trig),
    .crt_en(crt_en), .mod_len(mod_len), .exp_len(exp_len)
);

// File: tb/sim_crypto_bus_wrap.sv
`timescale 1ns/1ps
module sim_crypto_bus_wrap;
    localparam int OP_AW  = 4;
    localparam int ARRB   = 64;
    localparam int AW     = OP_AW + 4;
    localparam int LAT    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_cs = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic init_trig, next_trig, crt_en;
    logic [31:0] mod_len, exp_len;
    logic eng_ready, eng_valid;
    logic [2:0] eng_rd_bank = '0;
    logic [OP_AW-1:0] eng_rd_addr = '0;
    logic [31:0] eng_rd_data;
    logic eng_wr_en;
    logic [2:0] eng_wr_bank;
    logic [OP_AW-1:0] eng_wr_addr;
    logic [31:0] eng_wr_data;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    crypto_bus_wrap #(.OP_AW(OP_AW), .ARRAY_BITS(ARRB)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .init_trig(init_trig), .next_trig(next_trig), .crt_en(crt_en),
        .mod_len(mod_len), .exp_len(exp_len),
        .eng_ready(eng_ready), .eng_valid(eng_valid),
        .eng_rd_bank(eng_rd_bank), .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data),
        .eng_wr_en(eng_wr_en), .eng_wr_bank(eng_wr_bank),
        .eng_wr_addr(eng_wr_addr), .eng_wr_data(eng_wr_data)
    );

    // Stub engine: on a strobe, writes 4 or 8 known words, then raises its flag.
    logic busy, is_exp;
    logic [4:0] cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; is_exp <= 1'b0; cnt <= '0;
            eng_ready <= 1'b0; eng_valid <= 1'b0;
        end else if (!busy) begin
            if (init_trig) begin
                busy <= 1'b1; is_exp <= 1'b0; cnt <= '0; eng_ready <= 1'b0;
            end else if (next_trig) begin
                busy <= 1'b1; is_exp <= 1'b1; cnt <= '0; eng_valid <= 1'b0;
            end
        end else begin
            cnt <= cnt + 5'd1;
            if (cnt == 5'(LAT)) begin
                busy <= 1'b0;
                if (is_exp) eng_valid <= 1'b1;
                else        eng_ready <= 1'b1;
            end
        end
    end
    always_comb begin
        eng_wr_en   = busy && (is_exp ? (cnt < 5'd4) : (cnt < 5'd8));
        eng_wr_addr = OP_AW'(cnt[1:0]);
        if (is_exp) begin
            eng_wr_bank = 3'b011; eng_wr_data = 32'h5E5E0000 + 32'(cnt[1:0]);
        end else if (cnt < 5'd4) begin
            eng_wr_bank = 3'b100; eng_wr_data = 32'hC0EF0000 + 32'(cnt[1:0]);
        end else begin
            eng_wr_bank = 3'b110; eng_wr_data = 32'hFAC70000 + 32'(cnt[1:0]);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_cs = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [AW-1:0] bank_addr(input logic [2:0] b, input int w);
        return {1'b1, b, OP_AW'(w)};
    endfunction

    task automatic wait_flag(input int bitn);
        logic [31:0] s;
        int guard = 0;
        do begin
            bus_read(AW'(8'h09), s);
            guard++;
        end while (!s[bitn] && guard < 200);
        check("R6 flag rises", 32'(s[bitn]), 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R3 mod_len", mod_len, 0);
        check("R3 exp_len", exp_len, 0);
        check("R3 crt_en", 32'(crt_en), 0);
        bus_read(AW'(8'h08), d); check("R3 control", d, 0);
        bus_read(AW'(8'h10), d); check("R3 mode", d, 0);
        bus_read(AW'(8'h09), d); check("R6 idle status", d, 0);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        bus_read(AW'(8'h00), d); check("R1 id0", d, 32'h6D6F6465);
        bus_read(AW'(8'h01), d); check("R1 id1", d, 32'h78706137);
        bus_read(AW'(8'h02), d); check("R1 version", d, 32'h302E3235);
        bus_read(AW'(8'h13), d); check("R11 buffer width", d, 32'd512);
        bus_read(AW'(8'h14), d); check("R11 array width", d, ARRB);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_read(AW'(8'h05), d); check("R2 unmapped 05", d, 0);
        bus_read(AW'(8'h7F), d); check("R2 unmapped 7F", d, 0);
        bus_write(AW'(8'h00), 32'h12345678);
        bus_write(AW'(8'h13), 32'h0);
        bus_write(AW'(8'h09), 32'h3);
        bus_read(AW'(8'h00), d); check("R2 id0 after write", d, 32'h6D6F6465);
        bus_read(AW'(8'h13), d); check("R2 bufw after write", d, 32'd512);
        bus_read(AW'(8'h09), d); check("R2 status after write", d, 0);
    endtask

    task automatic t_mode_len();
        logic [31:0] d;
        bus_write(AW'(8'h11), 32'd384);
        bus_write(AW'(8'h12), 32'd192);
        bus_write(AW'(8'h10), 32'h2);
        check("R7 mod_len port", mod_len, 32'd384);
        check("R7 exp_len port", exp_len, 32'd192);
        check("R7 crt_en set", 32'(crt_en), 1);
        bus_read(AW'(8'h11), d); check("R7 mlen readback", d, 32'd384);
        bus_read(AW'(8'h10), d); check("R7 mode readback", d, 32'h2);
        bus_write(AW'(8'h10), 32'h1);
        check("R7 crt_en clear", 32'(crt_en), 0);
    endtask

    task automatic t_pulses();
        logic [31:0] d;
        bus_write(AW'(8'h08), 32'h0);
        bus_write(AW'(8'h08), 32'h1);
        check("R4 init pulse", 32'(init_trig), 1);
        check("R5 no next pulse", 32'(next_trig), 0);
        @(negedge clk);
        check("R4 init one clock", 32'(init_trig), 0);
        wait_flag(0);
        bus_write(AW'(8'h08), 32'h1);
        check("R5 rewrite 1 no pulse", 32'(init_trig), 0);
        bus_read(AW'(8'h08), d); check("R5 control readback", d, 32'h1);
    endtask

    task automatic t_init_banks();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            bus_read(bank_addr(3'b100, i), d); check("R9 coeff out", d, 32'hC0EF0000 + i);
            bus_read(bank_addr(3'b110, i), d); check("R9 factor out", d, 32'hFAC70000 + i);
            bus_write(bank_addr(3'b101, i), d ^ 32'hFFFF);
        end
        for (int i = 0; i < 4; i++) begin
            bus_read(bank_addr(3'b101, i), d); check("R8 coeff in restore", d, (32'hFAC70000 + i) ^ 32'hFFFF);
        end
        bus_write(bank_addr(3'b100, 0), 32'hDEADBEEF);
        bus_write(bank_addr(3'b011, 1), 32'hDEADBEEF);
        bus_read(bank_addr(3'b100, 0), d); check("R9 bus write ignored", d, 32'hC0EF0000);
    endtask

    task automatic t_exp();
        logic [31:0] d;
        bus_write(AW'(8'h08), 32'h1);
        bus_write(AW'(8'h08), 32'h3);
        check("R5 next pulse", 32'(next_trig), 1);
        check("R4 no init pulse", 32'(init_trig), 0);
        @(negedge clk);
        check("R5 next one clock", 32'(next_trig), 0);
        wait_flag(1);
        bus_read(AW'(8'h09), d); check("R6 both flags", d, 32'h3);
        for (int i = 0; i < 4; i++) begin
            bus_read(bank_addr(3'b011, i), d); check("R9 result", d, 32'h5E5E0000 + i);
        end
    endtask

    task automatic t_engine_read();
        logic [31:0] d;
        bus_write(bank_addr(3'b000, 0), 32'hA0000001);
        bus_write(bank_addr(3'b000, 15), 32'hA000000F);
        bus_write(bank_addr(3'b010, 2), 32'hE0000002);
        bus_write(bank_addr(3'b111, 3), 32'h77770003);
        bus_read(bank_addr(3'b000, 15), d); check("R8 modulus top word", d, 32'hA000000F);
        @(negedge clk); eng_rd_bank = 3'b000; eng_rd_addr = 0;
        @(negedge clk); check("R10 modulus word 0", eng_rd_data, 32'hA0000001);
        eng_rd_bank = 3'b010; eng_rd_addr = 2;
        @(negedge clk); check("R10 exponent word 2", eng_rd_data, 32'hE0000002);
        eng_rd_bank = 3'b111; eng_rd_addr = 3;
        @(negedge clk); check("R10 factor in word 3", eng_rd_data, 32'h77770003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ident();
        t_unmapped();
        t_mode_len();
        t_pulses();
        t_init_banks();
        t_exp();
        t_engine_read();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R3 reset clears mod_len", mod_len, 0);
        check("R3 reset clears crt_en", 32'(crt_en), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule